// File: doc/BRIEF.md
# Conditional Branch and Call Unit

This unit resolves the control-flow instructions of a 16-bit accumulator processor, which are the instructions whose top four bits are zero. A one-cycle `start` pulse presents the instruction word, its own program counter and the current accumulator. The unit then decides whether a branch is taken. It reads the trailing target word from memory when the instruction needs one. It finishes with a single-cycle `done` pulse that carries the following program counter. `pc_load` rises with `done` only when the flow is redirected. When `done` rises without `pc_load`, `next_pc` is the sequential address.

Bit 11 of the instruction splits it into two groups. When bit 11 is zero, bits 10:8 hold a branch condition. Code 0 is an unconditional long jump whose target is the next word. Codes 1 to 7 are short branches to the zero-extended low byte. When bit 11 is one, bits 10:8 equal to 0 mean CALL, 1 means RET, and 2 to 7 are left unassigned. A CALL pushes its return address onto an internal stack of return addresses. A RET pops that stack. A sticky error flag records any push to a full stack and any pop from an empty one.

The controller has four states. ST_IDLE waits for `start`. ST_READ drives the memory read of the word at PC+1. ST_WAIT captures that word. ST_DONE presents the result. The transitions are as follows. ST_IDLE moves to ST_READ on a JMP or CALL. ST_IDLE moves to ST_DONE on any other instruction with opcode 0. ST_READ always moves to ST_WAIT, and ST_WAIT always moves to ST_DONE. ST_DONE always returns to ST_IDLE. ST_IDLE stays in ST_IDLE when `start` is low or the opcode is not zero.

Top module: `bcu_branch_unit`

## Requirements
- R1: A `start` whose instruction bits 15:12 are not zero is ignored: no `done`, no `mem_rd` and no `pc_load` follow, and the stack is untouched.
- R2: With bit 11 = 0 and condition code c = bits 10:8 in 1..7, the branch is taken when the signed accumulator satisfies: 1 AC>0, 2 AC<0, 3 AC!=0, 4 AC==0, 5 AC>=0, 6 AC<=0, 7 always. Bit 15 is the sign, and zero means all 16 bits are zero.
- R3: A taken short branch gives `next_pc` = {8'h00, instr[7:0]} with `pc_load` = 1. `done` is high in the cycle after the `start` cycle.
- R4: A short branch that is not taken gives `next_pc` = PC+1 with `pc_load` = 0, also one cycle after `start`.
- R5: JMP (bits 11:8 = 0000) asserts `mem_rd` with `mem_addr` = PC+1 in the cycle after `start`. Memory returns data one cycle after the read. `done` follows three cycles after `start` with `next_pc` = that word and `pc_load` = 1.
- R6: CALL (bits 11:8 = 1000) reads its target like JMP and jumps to it. It pushes PC+2 as the return address.
- R7: RET (bits 11:8 = 1001) pops the most recent return address into `next_pc` with `pc_load` = 1, one cycle after `start`. The stack holds 8 entries in last-in, first-out order.
- R8: A CALL made while 8 entries are held pushes nothing and sets `stack_err`. It still consumes the target word: `next_pc` = PC+2 and `pc_load` = 0.
- R9: A RET made with an empty stack sets `stack_err` and gives `next_pc` = PC+1 with `pc_load` = 0. `stack_err` stays set until reset.
- R10: Codes with bit 11 = 1 and bits 10:8 in 2..7 act as no-ops: `next_pc` = PC+1, `pc_load` = 0, and the stack is unchanged.
- R11: After reset, `done`, `pc_load`, `mem_rd` and `stack_err` are low and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to resolve `instr` |
| instr | input | 16 | Instruction word |
| pc | input | 16 | Address of the instruction |
| acc | input | 16 | Accumulator value |
| mem_rd | output | 1 | Read request for the trailing word |
| mem_addr | output | 16 | Read address, equal to PC+1 |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| next_pc | output | 16 | Following program counter, valid with `done` |
| pc_load | output | 1 | Redirect strobe, only with `done` |
| done | output | 1 | Instruction resolved |
| stack_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
A controller stuck in the wrong state shows as a `done` pulse at the wrong latency or a stray `mem_rd`, and this is visible within one to three cycles of the `start` that exposed it. A wrong stack count or a corrupted entry stays hidden until a later RET. That RET then returns the wrong address, or `stack_err` rises at the wrong depth. The bench therefore pairs random calls and returns with a full fill-and-drain sequence, so every slot is read back.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_DONE
    } bcu_state_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SHORT,
        OP_JMP,
        OP_CALL,
        OP_RET,
        OP_NOP
    } bcu_op_t;
endpackage

// File: rtl/bcu_decode.sv
module bcu_decode
    import bcu_pkg::*;
(
    input  logic [15:0] instr,
    output bcu_op_t     op,
    output logic [2:0]  cond
);
    assign cond = instr[10:8];

    always_comb begin
        if (instr[15:12] != 4'h0) begin
            op = OP_NONE;                     // R1: other opcodes ignored
        end else if (!instr[11]) begin
            op = (instr[10:8] == 3'd0) ? OP_JMP : OP_SHORT;
        end else begin
            unique case (instr[10:8])
                3'd0:    op = OP_CALL;
                3'd1:    op = OP_RET;
                default: op = OP_NOP;         // R10
            endcase
        end
    end
endmodule

// File: rtl/bcu_cond.sv
module bcu_cond #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc,
    input  logic [2:0]   cond,
    output logic         take
);
    logic neg;
    logic zero;

    assign neg  = acc[W-1];
    assign zero = (acc == '0);

    // R2: signed tests on the accumulator
    always_comb begin
        unique case (cond)
            3'd1:    take = !neg && !zero;
            3'd2:    take = neg;
            3'd3:    take = !zero;
            3'd4:    take = zero;
            3'd5:    take = !neg;
            3'd6:    take = neg || zero;
            3'd7:    take = 1'b1;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcu_ret_stack.sv
module bcu_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty,
    output logic         err
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slot_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;

    assign full   = (cnt_q == CNT_W'(DEPTH));
    assign empty  = (cnt_q == '0);
    assign wr_idx = PTR_W'(cnt_q);
    assign rd_idx = PTR_W'(cnt_q - 1'b1);
    assign top    = slot_q[rd_idx];
    assign err    = err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (push) begin
                if (full) err_q <= 1'b1;
                else      cnt_q <= cnt_q + 1'b1;
            end else if (pop) begin
                if (empty) err_q <= 1'b1;
                else       cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full) slot_q[wr_idx] <= push_data;
    end

    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (cnt_q == $past(cnt_q)) && err_q);
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (cnt_q == $past(cnt_q)) && err_q);
endmodule

// File: rtl/bcu_branch_unit.sv
module bcu_branch_unit
    import bcu_pkg::*;
#(
    parameter int W         = 16,
    parameter int RET_DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] instr,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] acc,
    output logic         mem_rd,
    output logic [W-1:0] mem_addr,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] next_pc,
    output logic         pc_load,
    output logic         done,
    output logic         stack_err
);
    localparam int PAY_W = 8;

    bcu_state_t   state_q, state_d;
    bcu_op_t      op, op_q;
    logic [2:0]   cond;
    logic         take;
    logic [W-1:0] pc_q;
    logic [W-1:0] next_pc_q;
    logic         load_q;
    logic         accept;
    logic         push, pop;
    logic [W-1:0] stk_top;
    logic         stk_full, stk_empty;
    logic [W-1:0] seq_pc;
    logic [W-1:0] short_tgt;

    bcu_decode u_dec (.instr(instr), .op(op), .cond(cond));

    bcu_cond #(.W(W)) u_cond (.acc(acc), .cond(cond), .take(take));

    bcu_ret_stack #(.DEPTH(RET_DEPTH), .W(W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_data(pc_q + W'(2)), .top(stk_top),
        .full(stk_full), .empty(stk_empty), .err(stack_err)
    );

    assign accept    = (state_q == ST_IDLE) && start && (op != OP_NONE);
    assign pop       = accept && (op == OP_RET);
    assign push      = (state_q == ST_WAIT) && (op_q == OP_CALL);
    assign seq_pc    = pc + W'(1);
    assign short_tgt = {{(W-PAY_W){1'b0}}, instr[PAY_W-1:0]};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)
                         state_d = (op == OP_JMP || op == OP_CALL) ? ST_READ : ST_DONE;
            ST_READ: state_d = ST_WAIT;
            ST_WAIT: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q      <= '0;
            op_q      <= OP_NONE;
            next_pc_q <= '0;
            load_q    <= 1'b0;
        end else if (accept) begin
            pc_q <= pc;
            op_q <= op;
            unique case (op)
                OP_SHORT: begin
                    next_pc_q <= take ? short_tgt : seq_pc;
                    load_q    <= take;
                end
                OP_RET: begin
                    next_pc_q <= stk_empty ? seq_pc : stk_top;
                    load_q    <= !stk_empty;
                end
                default: begin
                    next_pc_q <= seq_pc;
                    load_q    <= 1'b0;
                end
            endcase
        end else if (state_q == ST_WAIT) begin
            if (op_q == OP_CALL && stk_full) begin
                next_pc_q <= pc_q + W'(2);
                load_q    <= 1'b0;
            end else begin
                next_pc_q <= mem_rdata;
                load_q    <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        mem_rd   = (state_q == ST_READ);
        mem_addr = pc_q + W'(1);
        done     = (state_q == ST_DONE);
        pc_load  = (state_q == ST_DONE) && load_q;
        next_pc  = next_pc_q;
    end

    assert_load_needs_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> done);
    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_read_then_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd && !done);
    assert_ignore_other_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && start && (instr[15:12] != 4'h0)) |=> !done && !mem_rd);
    assert_read_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr == $past(pc) + W'(1)));
endmodule

// File: tb/test_bcu_branch_unit.sv
`timescale 1ns/1ps
module test_bcu_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0, pc = '0, acc = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic [15:0] next_pc;
    logic        pc_load, done, stack_err;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] mem_word = '0;
    logic [15:0] exp_addr = '0;
    logic [15:0] m_stack [8];
    int          m_cnt = 0;
    bit          m_err = 0;

    bcu_branch_unit i_bcu_branch_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc),
        .acc(acc), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .next_pc(next_pc), .pc_load(pc_load), .done(done), .stack_err(stack_err)
    );

    always #2.5 clk = ~clk;

    // memory model: one-cycle read latency, wrong address returns a marker
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= (mem_addr == exp_addr) ? mem_word : 16'hDEAD;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_take(input logic [2:0] c, input logic [15:0] a);
        bit s = a[15];
        bit z = (a == 16'h0);
        case (c)
            3'd1: return !s && !z;
            3'd2: return s;
            3'd3: return !z;
            3'd4: return z;
            3'd5: return !s;
            3'd6: return s || z;
            3'd7: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0;
        m_err = 0;
        @(negedge clk);
        check(!done && !pc_load && !mem_rd && !stack_err, "R11 reset outputs",
              {done, pc_load, mem_rd, stack_err}, 0);
    endtask

    task automatic run_instr(input logic [15:0] ir, input logic [15:0] pcv,
                             input logic [15:0] accv, input logic [15:0] word);
        int          lat;
        logic [15:0] e_next;
        bit          e_load;
        string       req;
        int          got_lat;
        logic [15:0] got_next;
        bit          got_load;
        bit          rd_seen;
        int          rd_cyc;

        e_next = pcv + 16'd1;
        e_load = 0;
        lat    = 1;
        if (ir[15:12] != 4'h0) begin
            lat = 0; req = "R1";
        end else if (!ir[11]) begin
            if (ir[10:8] == 3'd0) begin
                lat = 3; e_next = word; e_load = 1; req = "R5";
            end else if (exp_take(ir[10:8], accv)) begin
                e_next = {8'h00, ir[7:0]}; e_load = 1; req = "R2/R3";
            end else begin
                req = "R2/R4";
            end
        end else begin
            case (ir[10:8])
                3'd0: begin
                    lat = 3;
                    if (m_cnt < 8) begin
                        m_stack[m_cnt] = pcv + 16'd2;
                        m_cnt++;
                        e_next = word; e_load = 1; req = "R6";
                    end else begin
                        m_err = 1; e_next = pcv + 16'd2; req = "R8";
                    end
                end
                3'd1: begin
                    if (m_cnt > 0) begin
                        m_cnt--;
                        e_next = m_stack[m_cnt]; e_load = 1; req = "R7";
                    end else begin
                        m_err = 1; req = "R9";
                    end
                end
                default: req = "R10";
            endcase
        end

        instr = ir; pc = pcv; acc = accv;
        mem_word = word; exp_addr = pcv + 16'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        instr = $urandom; pc = $urandom; acc = $urandom;
        got_lat = 0; got_next = '0; got_load = 0; rd_seen = 0; rd_cyc = 0;
        for (int c = 1; c <= 4; c++) begin
            if (mem_rd && !rd_seen) begin rd_seen = 1; rd_cyc = c; end
            if (done && got_lat == 0) begin
                got_lat = c; got_next = next_pc; got_load = pc_load;
            end
            if (c < 4) @(negedge clk);
        end
        check(got_lat == lat, {req, " latency"}, got_lat, lat);
        if (lat == 3)
            check(rd_seen && rd_cyc == 1, {req, " read cycle"}, rd_cyc, 1);
        else
            check(!rd_seen, {req, " no read"}, rd_seen, 0);
        if (lat != 0) begin
            check(got_next == e_next, {req, " next_pc"}, got_next, e_next);
            check(got_load == e_load, {req, " pc_load"}, got_load, e_load);
        end
        check(stack_err == m_err, {req, " stack_err"}, stack_err, m_err);
    endtask

    initial begin
        #(100000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7919));
        do_reset();

        // R1: other opcodes ignored
        run_instr(16'h1742, 16'h0100, 16'h0000, 16'h1111);
        run_instr(16'hF008, 16'h0200, 16'h8000, 16'h2222);
        // R2 boundaries: zero, max positive, min negative, minus one
        for (int c = 1; c <= 7; c++) begin
            run_instr({4'h0, 1'b0, 3'(c), 8'h5A}, 16'h0300, 16'h0000, 16'h0);
            run_instr({4'h0, 1'b0, 3'(c), 8'hC3}, 16'h0310, 16'h7FFF, 16'h0);
            run_instr({4'h0, 1'b0, 3'(c), 8'h81}, 16'h0320, 16'h8000, 16'h0);
            run_instr({4'h0, 1'b0, 3'(c), 8'hFF}, 16'h0330, 16'hFFFF, 16'h0);
        end
        // R5 JMP
        run_instr(16'h0000, 16'h1234, 16'h0000, 16'hBEEF);
        run_instr(16'h00AA, 16'hFFFF, 16'h0001, 16'h4321);
        // R10 unassigned codes with an empty stack leave err low
        for (int c = 2; c <= 7; c++)
            run_instr({4'h0, 1'b1, 3'(c), 8'h33}, 16'h0400 + 16'(c), 16'h0, 16'h0);
        // R6/R7/R8: fill, overflow, drain
        for (int k = 0; k < 9; k++)
            run_instr(16'h0800, 16'h2000 + 16'(k * 16), 16'h0, 16'h3000 + 16'(k));
        for (int k = 0; k < 8; k++)
            run_instr(16'h0900, 16'h5000, 16'h0, 16'h0);
        run_instr(16'h0900, 16'h5100, 16'h0, 16'h0);

        // R9: underflow from a clean reset
        do_reset();
        run_instr(16'h0900, 16'h6000, 16'h0, 16'h0);
        run_instr(16'h0700, 16'h6010, 16'h0, 16'h0);

        // random mix after a fresh reset
        do_reset();
        for (int i = 0; i < 400; i++) begin
            logic [15:0] ir, a;
            ir = {4'h0, 4'($urandom), 8'($urandom)};
            if (($urandom % 16) == 0) ir[15:12] = 4'($urandom % 15 + 1);
            case ($urandom % 4)
                0: a = 16'h0000;
                1: a = 16'h8000 | 16'($urandom);
                default: a = 16'($urandom);
            endcase
            run_instr(ir, 16'($urandom), a, 16'($urandom));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule